// File: doc/BRIEF.md
# Eight-Level Prioritized Interrupt Controller

This block collects interrupt requests from a set of sources and offers the CPU one vector at a time. The sources can be peripherals inside the chip, external pins, or the CPU itself raising a software request on a source line. Software writes each source's mask bit and priority level, one source per write. An unmasked request pulse sets the pending bit of the level that the source is assigned to. There is one pending bit per level, so sources that share a level also share that bit.

There are eight levels. Level 7 is served first and level 0 last, and this order is fixed in hardware. Each level has its own vector address, equal to a base plus the level times a fixed spacing. A request is latched even while the global enable input is low. The vector is offered only while that input is high.

Each level has an in-service bit. Only a pending level that is strictly higher than the highest in-service level can interrupt. An acknowledge of the offered vector moves that level from pending to in-service. An end-of-service pulse retires the highest level that is in service.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, all sources are masked and assigned to level 0, and no level is pending or in service. `irq_valid` is low.
- R2: A request pulse on an unmasked source sets the pending bit of that source's level. A request on a masked source is not latched, so unmasking the source later produces no interrupt.
- R3: While `gie` is low, `irq_valid` is low and pending levels are kept. When `gie` goes high, the pending levels are offered in the same cycle.
- R4: The offered level `irq_lvl` is the highest pending level, with level 7 highest. `irq_vec` equals VEC_BASE + `irq_lvl`*VEC_STEP. The defaults are 0x040 and 4.
- R5: `irq_ack` sampled while `irq_valid` is high clears the offered level's pending bit and sets its in-service bit. An `irq_ack` while `irq_valid` is low has no effect.
- R6: `irq_valid` is high only when the highest pending level is strictly above every in-service level. A pending level equal to or below the highest in-service level waits.
- R7: An `eos` pulse clears the highest set in-service bit. When no level is in service, `eos` has no effect.
- R8: Several sources that share a level set one pending bit. Requests from all of them are served by a single acknowledge.
- R9: A configuration write (`cfg_we`) takes effect on the next cycle. A request in the same cycle as the write uses the source's previous mask and level.
- R10: A new request to a level in the same cycle as that level's acknowledge leaves the level pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | NUM_SRC | Request pulses, one bit per source |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | SRC_W | Source selected by the write |
| cfg_mask | input | 1 | Mask bit written; 1 masks the source |
| cfg_lvl | input | 3 | Level written for the source |
| gie | input | 1 | Global interrupt enable |
| irq_valid | output | 1 | A vector is offered |
| irq_lvl | output | 3 | Offered level |
| irq_vec | output | VEC_W | Offered vector address |
| irq_ack | input | 1 | CPU accepts the offered vector |
| eos | input | 1 | End of service of the current routine |

## Verification
The hardest states to reach are those with nested service. In these, several in-service bits are set while pending bits sit at, below and above the top in-service level, which tests strict preemption and the order of end-of-service. A directed sequence builds a two-deep nesting. Sources are reassigned so that one pending level equals the active in-service level. The sequence then retires the nesting one level at a time. A long random phase follows. It uses frequent acknowledge and end-of-service pulses and occasional `gie` drops, and it reconfigures sources as it runs. Deep nests, same-cycle acknowledge and request, and same-cycle configuration and request all arise in it.

// File: rtl/prio_irq_ctrl.sv
`timescale 1ns/1ps
module prio_irq_ctrl #(
  parameter int NUM_SRC = 8,
  parameter int VEC_W = 12,
  parameter int unsigned VEC_BASE = 32'h040,
  parameter int unsigned VEC_STEP = 4,
  parameter int SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_req,
  input  logic               cfg_we,
  input  logic [SRC_W-1:0]   cfg_idx,
  input  logic               cfg_mask,
  input  logic [2:0]         cfg_lvl,
  input  logic               gie,
  output logic               irq_valid,
  output logic [2:0]         irq_lvl,
  output logic [VEC_W-1:0]   irq_vec,
  input  logic               irq_ack,
  input  logic               eos
);
  localparam int NLVL = 8;

  logic [NUM_SRC-1:0] mask_q;
  logic [2:0]         lvl_q [NUM_SRC];
  logic [NLVL-1:0]    pend_q, isr_q, set_vec, ack_bit, eos_bit;
  logic [2:0]         top_pend, cur_isr;
  logic               ack_go;

  function automatic logic [2:0] top_of(input logic [NLVL-1:0] v);
    top_of = '0;
    for (int i = 0; i < NLVL; i++)
      if (v[i]) top_of = 3'(i);
  endfunction

  always_comb begin
    set_vec = '0;
    for (int s = 0; s < NUM_SRC; s++)
      if (irq_req[s] && !mask_q[s]) set_vec[lvl_q[s]] = 1'b1;
  end

  assign top_pend  = top_of(pend_q);
  assign cur_isr   = top_of(isr_q);
  assign irq_valid = gie && (|pend_q) && (~|isr_q || top_pend > cur_isr);
  assign irq_lvl   = top_pend;
  assign irq_vec   = VEC_W'(VEC_BASE + 32'(top_pend) * VEC_STEP);
  assign ack_go    = irq_valid && irq_ack;
  assign ack_bit   = ack_go ? (NLVL'(1) << top_pend) : '0;
  assign eos_bit   = (eos && |isr_q) ? (NLVL'(1) << cur_isr) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      isr_q  <= '0;
    end else begin
      pend_q <= (pend_q & ~ack_bit) | set_vec;
      isr_q  <= (isr_q & ~eos_bit) | ack_bit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      for (int s = 0; s < NUM_SRC; s++) lvl_q[s] <= '0;
    end else if (cfg_we) begin
      mask_q[cfg_idx] <= cfg_mask;
      lvl_q[cfg_idx]  <= cfg_lvl;
    end
  end
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
`timescale 1ns/1ps
module prio_irq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       gie,
  input logic       irq_valid,
  input logic       irq_ack,
  input logic [2:0] irq_lvl,
  input logic       eos,
  input logic [7:0] pend_q,
  input logic [7:0] isr_q
);
  p_gie_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !gie |-> !irq_valid);

  p_top_pending_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (pend_q >> irq_lvl) == 8'd1);

  p_strict_preempt_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (isr_q >> irq_lvl) == 8'd0);

  p_ack_in_service_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid && irq_ack |=> isr_q[$past(irq_lvl)]);

  p_eos_retires_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
    eos && isr_q != 8'd0 && !(irq_valid && irq_ack)
    |=> $countones(isr_q) == $countones($past(isr_q)) - 1);
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .gie(gie), .irq_valid(irq_valid),
  .irq_ack(irq_ack), .irq_lvl(irq_lvl), .eos(eos),
  .pend_q(pend_q), .isr_q(isr_q)
);

// File: tb/tb_prio_irq_ctrl.sv
`timescale 1ns/1ps
module tb_prio_irq_ctrl;
  localparam int NS = 8;
  localparam int BASE = 'h040;
  localparam int STEP = 4;

  logic clk = 0, rst_n = 0;
  logic [NS-1:0] req = '0;
  logic cfg_we = 0, cfg_mask = 0, gie = 0, ack = 0, eos = 0;
  logic [2:0] cfg_idx = '0, cfg_lvl = '0;
  logic irq_valid;
  logic [2:0] irq_lvl;
  logic [11:0] irq_vec;

  int tests = 0, fails = 0, cycles = 0;

  logic       m_mask [NS];
  logic [2:0] m_lvl  [NS];
  logic [7:0] m_pend, m_isr;

  prio_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .irq_req(req), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_mask(cfg_mask), .cfg_lvl(cfg_lvl), .gie(gie), .irq_valid(irq_valid),
    .irq_lvl(irq_lvl), .irq_vec(irq_vec), .irq_ack(ack), .eos(eos)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: run hung, act=%0d exp=<150000", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  function automatic int top_of(logic [7:0] v);
    int t = 0;
    for (int i = 0; i < 8; i++) if (v[i]) t = i;
    return t;
  endfunction

  function automatic logic exp_valid();
    return gie && (m_pend != 0) && (m_isr == 0 || top_of(m_pend) > top_of(m_isr));
  endfunction

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int s = 0; s < NS; s++) begin m_mask[s] = 1; m_lvl[s] = 0; end
    m_pend = 0; m_isr = 0;
  endtask

  task automatic step();
    logic v;
    int tl;
    logic [7:0] np, ni;
    #0.5;
    v = exp_valid();
    tl = top_of(m_pend);
    chk("R3 valid", irq_valid, v);
    if (v) begin
      chk("R4 level", irq_lvl, tl);
      chk("R4 vector", irq_vec, BASE + tl * STEP);
    end
    np = m_pend; ni = m_isr;
    if (eos && m_isr != 0) ni[top_of(m_isr)] = 0;
    if (ack && v) begin np[tl] = 0; ni[tl] = 1; end
    for (int s = 0; s < NS; s++) if (req[s] && !m_mask[s]) np[m_lvl[s]] = 1;
    @(posedge clk);
    #1;
    m_pend = np; m_isr = ni;
    if (cfg_we) begin m_mask[cfg_idx] = cfg_mask; m_lvl[cfg_idx] = cfg_lvl; end
    req = '0; ack = 0; eos = 0; cfg_we = 0;
  endtask

  task automatic cfg(int idx, logic msk, int lv);
    cfg_we = 1; cfg_idx = 3'(idx); cfg_mask = msk; cfg_lvl = 3'(lv);
  endtask

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset valid", irq_valid, 0);
    rst_n = 1;
    gie = 1;
    #0.5 chk("R1 nothing pending", irq_valid, 0);
    #0.5;

    req[0] = 1; step();
    cfg(0, 0, 2); step();
    step();
    chk("R2 masked req not latched", irq_valid, 0);

    cfg(1, 0, 5); req[1] = 1; step();
    step();
    chk("R9 same-cycle cfg uses old mask", irq_valid, 0);

    gie = 0; req[1] = 1; step();
    step(); step();
    #0.5 chk("R3 gie low blocks", irq_valid, 0); #0.5;
    gie = 1;
    #0.5 chk("R3 dispatch on gie", irq_valid, 1);
    chk("R4 vector lvl5", irq_vec, 'h054); #0.5;

    req[0] = 1; step();
    #0.5 chk("R4 highest first", irq_lvl, 5); #0.5;
    ack = 1; step();
    #0.5 chk("R6 lower waits", irq_valid, 0); #0.5;

    cfg(2, 0, 5); step();
    req[2] = 1; step();
    #0.5 chk("R6 equal no preempt", irq_valid, 0); #0.5;
    cfg(3, 0, 7); step();
    req[3] = 1; step();
    #0.5 chk("R6 higher preempts", irq_valid, 1);
    chk("R6 lvl7", irq_lvl, 7); #0.5;
    ack = 1; step();

    eos = 1; step();
    #0.5 chk("R7 eos keeps lvl5 active", irq_valid, 0); #0.5;
    eos = 1; step();
    #0.5 chk("R7 eos retires lvl5", irq_lvl, 5);
    chk("R7 valid", irq_valid, 1); #0.5;
    ack = 1; step();
    eos = 1; step();
    #0.5 chk("R7 lvl2 next", irq_lvl, 2); #0.5;

    gie = 0; ack = 1; step();
    gie = 1;
    #0.5 chk("R5 stray ack ignored", irq_valid, 1);
    chk("R5 still lvl2", irq_lvl, 2); #0.5;

    cfg(4, 0, 6); step();
    cfg(5, 0, 6); step();
    req[4] = 1; req[5] = 1; step();
    ack = 1; step();
    eos = 1; step();
    #0.5 chk("R8 shared level served once", irq_lvl, 2); #0.5;

    ack = 1; req[0] = 1; step();
    eos = 1; step();
    #0.5 chk("R10 req during ack stays pending", irq_valid, 1);
    chk("R10 lvl2 again", irq_lvl, 2); #0.5;
    ack = 1; step();
    eos = 1; step();
    eos = 1; step();
    #0.5 chk("R7 eos with none in service", irq_valid, 0); #0.5;

    void'($urandom(2024));
    for (int i = 0; i < 4000; i++) begin
      req = (($urandom % 4) == 0) ? NS'($urandom) : '0;
      gie = ($urandom % 8) != 0;
      ack = $urandom % 2;
      eos = ($urandom % 5) == 0;
      if (($urandom % 10) == 0) cfg($urandom % NS, ($urandom % 4) == 0, $urandom % 8);
      step();
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule